// File: doc/BRIEF.md
# Programmable Supply Threshold Detector

This block watches a supply voltage that arrives as an unsigned millivolt code, for example from a converter, and compares it with one of eight selectable trip levels. A detector output goes high while the supply is too low. Hysteresis keeps that output from chattering around the trip level. The same output can raise a one-cycle interrupt when the supply falls below the level, when it recovers, or in both cases. The recovery trip point sits one hysteresis step above the falling trip point.

The enable, the level select and a lock request are sampled into configuration registers on each clock edge. After the lock engages, those registers keep their values until reset. This lets start-up code fix the supervisor settings so that later code cannot weaken them. Each time the detector is switched on, the first result comes from a plain comparison, and that first result raises no interrupt.

Top module: `supply_thresh_det`

## Requirements
- R1: Level code k (0..7 on `thr_sel`) gives a lower trip point of 2200 + 100*k mV and an upper trip point 100 mV higher, compared against `supply_mv` read as unsigned millivolts.
- R2: While enabled and past the first evaluation, a supply below the lower trip point sets `below_o` at the next clock edge.
- R3: A supply at or above the upper trip point clears `below_o` at the next edge. A supply inside [lower, upper) leaves `below_o` unchanged.
- R4: While the registered enable is 0, `below_o` and `irq_o` are 0 and supply changes have no effect.
- R5: A 0-to-1 change of `below_o` with `irq_drop_en` = 1 raises `irq_o` for exactly the cycle in which `below_o` first reads 1. With `irq_drop_en` = 0 there is no pulse.
- R6: A 1-to-0 change of `below_o` with `irq_recover_en` = 1 raises a one-cycle `irq_o` in the same cycle. With `irq_recover_en` = 0 there is no pulse.
- R7: `det_en` and `thr_sel` are registered on each edge unless the lock is already set. A value presented in the same cycle as the first `lock_req` is still taken. Later values are ignored.
- R8: The lock stays set after `lock_req` returns to 0 and clears only on reset.
- R9: On the first evaluation after enabling, `below_o` loads (supply < lower trip point) with no interrupt pulse, whatever the edge enables are.
- R10: After reset the detector is disabled, unlocked, at level code 0, with `below_o` = 0 and `irq_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Detector enable value |
| thr_sel | input | 3 | Level code value |
| lock_req | input | 1 | Request to freeze the configuration |
| irq_drop_en | input | 1 | Pulse when the supply falls below the trip point |
| irq_recover_en | input | 1 | Pulse when the supply recovers |
| supply_mv | input | 12 | Supply voltage in millivolts |
| below_o | output | 1 | 1 while the supply is judged low |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Two events can land in the same cycle. One is the first lock request arriving together with a new level code and enable value. The other is an edge pulse arriving together with a change of the detector's own state. For the first, the bench presents level code 5 together with `lock_req`, and then presents a different code, a disable and a released lock. It then checks at `below_o` that the trip level of code 5 still applies and that the detector is still on. For the second, the bench confirms that each pulse appears in exactly the cycle where `below_o` changes, and that enabling on a low supply changes `below_o` without any pulse.

// File: rtl/ptd_pkg.sv
package ptd_pkg;
  function automatic int lower_trip(int code, int base_mv, int step_mv);
    return base_mv + code * step_mv;
  endfunction

  function automatic int upper_trip(int code, int base_mv, int step_mv, int hyst_mv);
    return lower_trip(code, base_mv, step_mv) + hyst_mv;
  endfunction
endpackage

// File: rtl/ptd_cfg_reg.sv
module ptd_cfg_reg #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             lock_req,
  output logic             en_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             lock_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_q | lock_req;
      if (!lock_q) begin
        en_q  <= wr_en;
        sel_q <= wr_sel;
      end
    end
  end
endmodule

// File: rtl/ptd_hyst.sv
module ptd_hyst #(
  parameter int MV_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [MV_W-1:0] supply,
  input  logic [MV_W-1:0] lo_mv,
  input  logic [MV_W-1:0] hi_mv,
  output logic            below_q,
  output logic            below_nxt,
  output logic            init_pend
);
  logic under_lo, over_hi;

  assign under_lo = supply < lo_mv;
  assign over_hi  = supply >= hi_mv;

  always_comb begin
    if (!en)            below_nxt = 1'b0;
    else if (init_pend) below_nxt = under_lo;
    else if (under_lo)  below_nxt = 1'b1;
    else if (over_hi)   below_nxt = 1'b0;
    else                below_nxt = below_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      below_q   <= 1'b0;
      init_pend <= 1'b1;
    end else begin
      below_q   <= below_nxt;
      init_pend <= !en;
    end
  end
endmodule

// File: rtl/ptd_edge.sv
module ptd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic below_q,
  input  logic below_nxt,
  input  logic drop_en,
  input  logic rec_en,
  output logic irq_q
);
  logic went_low, went_ok;

  assign went_low = below_nxt & ~below_q;
  assign went_ok  = ~below_nxt & below_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= arm & ((went_low & drop_en) | (went_ok & rec_en));
  end
endmodule

// File: rtl/supply_thresh_det.sv
module supply_thresh_det #(
  parameter int MV_W    = 12,
  parameter int SEL_W   = 3,
  parameter int BASE_MV = 2200,
  parameter int STEP_MV = 100,
  parameter int HYST_MV = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en,
  input  logic [SEL_W-1:0] thr_sel,
  input  logic             lock_req,
  input  logic             irq_drop_en,
  input  logic             irq_recover_en,
  input  logic [MV_W-1:0]  supply_mv,
  output logic             below_o,
  output logic             irq_o
);
  import ptd_pkg::*;

  logic             en_eff;
  logic [SEL_W-1:0] sel_eff;
  logic             lock_eff;
  logic [MV_W-1:0]  lo_mv, hi_mv;
  logic             below_nxt;
  logic             init_pend;

  ptd_cfg_reg #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(det_en), .wr_sel(thr_sel),
    .lock_req(lock_req), .en_q(en_eff), .sel_q(sel_eff), .lock_q(lock_eff)
  );

  assign lo_mv = MV_W'(lower_trip(int'(sel_eff), BASE_MV, STEP_MV));
  assign hi_mv = MV_W'(upper_trip(int'(sel_eff), BASE_MV, STEP_MV, HYST_MV));

  ptd_hyst #(.MV_W(MV_W)) u_hyst (
    .clk(clk), .rst_n(rst_n), .en(en_eff), .supply(supply_mv),
    .lo_mv(lo_mv), .hi_mv(hi_mv), .below_q(below_o),
    .below_nxt(below_nxt), .init_pend(init_pend)
  );

  ptd_edge u_edge (
    .clk(clk), .rst_n(rst_n), .arm(en_eff & ~init_pend),
    .below_q(below_o), .below_nxt(below_nxt),
    .drop_en(irq_drop_en), .rec_en(irq_recover_en), .irq_q(irq_o)
  );
endmodule

// File: rtl/ptd_checker.sv
module ptd_checker #(
  parameter int MV_W  = 12,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_eff,
  input logic [SEL_W-1:0] sel_eff,
  input logic             lock_eff,
  input logic             init_pend,
  input logic [MV_W-1:0]  lo_mv,
  input logic [MV_W-1:0]  hi_mv,
  input logic [MV_W-1:0]  supply_mv,
  input logic             below_o,
  input logic             irq_o
);
  // R2
  set_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && !init_pend && supply_mv < lo_mv) |=> below_o);

  // R3
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && !init_pend && supply_mv >= lo_mv && supply_mv < hi_mv) |=> $stable(below_o));

  // R3
  clear_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && !init_pend && supply_mv >= hi_mv) |=> !below_o);

  // R4
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_eff |=> (!below_o && !irq_o));

  // R5
  pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (below_o != $past(below_o)));

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_eff |=> ($stable(sel_eff) && $stable(en_eff)));

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_eff |=> lock_eff);

  // R9
  first_eval_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && init_pend) |=> !irq_o);
endmodule

bind supply_thresh_det ptd_checker #(.MV_W(MV_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_eff(en_eff), .sel_eff(sel_eff),
  .lock_eff(lock_eff), .init_pend(init_pend), .lo_mv(lo_mv), .hi_mv(hi_mv),
  .supply_mv(supply_mv), .below_o(below_o), .irq_o(irq_o)
);

// File: tb/supply_thresh_det_tb.sv
module supply_thresh_det_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        det_en = 1'b0;
  logic [2:0]  thr_sel = 3'd0;
  logic        lock_req = 1'b0;
  logic        irq_drop_en = 1'b0;
  logic        irq_recover_en = 1'b0;
  logic [11:0] supply_mv = 12'd3300;
  logic        below_o, irq_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  supply_thresh_det u_dut (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .thr_sel(thr_sel),
    .lock_req(lock_req), .irq_drop_en(irq_drop_en),
    .irq_recover_en(irq_recover_en), .supply_mv(supply_mv),
    .below_o(below_o), .irq_o(irq_o)
  );

  function automatic int lo_of(int k);
    return 2200 + k * 100;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic b_exp, logic i_exp);
    checks++;
    if (below_o !== b_exp || irq_o !== i_exp) begin
      failures++;
      $display("FAIL %s below=%0b irq=%0b expected below=%0b irq=%0b",
               req, below_o, irq_o, b_exp, i_exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    det_en = 1'b0; thr_sel = 3'd0; lock_req = 1'b0;
    irq_drop_en = 1'b0; irq_recover_en = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic enable_at(int k, int mv);
    det_en = 1'b0; step(); step();
    det_en = 1'b1; thr_sel = 3'(k); supply_mv = 12'(mv);
    step(); step();
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 reset", 1'b0, 1'b0);
  endtask

  task automatic t_levels();
    for (int k = 0; k < 8; k++) begin
      enable_at(k, lo_of(k) - 1);
      check("R1 first eval under lower trip", 1'b1, 1'b0);
      supply_mv = 12'(lo_of(k)); step();
      check("R3 hold at lower trip", 1'b1, 1'b0);
      supply_mv = 12'(lo_of(k) + 99); step();
      check("R3 hold just under upper trip", 1'b1, 1'b0);
      supply_mv = 12'(lo_of(k) + 100); step();
      check("R3 clear at upper trip", 1'b0, 1'b0);
      supply_mv = 12'(lo_of(k)); step();
      check("R3 hold low band", 1'b0, 1'b0);
      supply_mv = 12'(lo_of(k) - 1); step();
      check("R2 set under lower trip", 1'b1, 1'b0);
    end
  endtask

  task automatic t_irq();
    irq_drop_en = 1'b1; irq_recover_en = 1'b0;
    enable_at(3, 3000);
    check("R9 enable high supply", 1'b0, 1'b0);
    supply_mv = 12'd2499; step();
    check("R5 drop pulse", 1'b1, 1'b1);
    step();
    check("R5 pulse one cycle", 1'b1, 1'b0);
    supply_mv = 12'd2600; step();
    check("R6 recover masked", 1'b0, 1'b0);
    irq_drop_en = 1'b0; irq_recover_en = 1'b1;
    supply_mv = 12'd2400; step();
    check("R5 drop masked", 1'b1, 1'b0);
    supply_mv = 12'd2700; step();
    check("R6 recover pulse", 1'b0, 1'b1);
    step();
    check("R6 pulse one cycle", 1'b0, 1'b0);
  endtask

  task automatic t_init();
    irq_drop_en = 1'b1; irq_recover_en = 1'b1;
    enable_at(0, 2000);
    check("R9 first eval low no pulse", 1'b1, 1'b0);
  endtask

  task automatic t_disable();
    det_en = 1'b0; step(); step();
    check("R4 disabled clears level, no pulse", 1'b0, 1'b0);
    supply_mv = 12'd1500; step(); step();
    check("R4 supply ignored while off", 1'b0, 1'b0);
  endtask

  task automatic t_lock();
    irq_drop_en = 1'b0; irq_recover_en = 1'b0;
    enable_at(2, 3000);
    check("R7 pre-lock level", 1'b0, 1'b0);
    thr_sel = 3'd5; lock_req = 1'b1; step();
    thr_sel = 3'd0; det_en = 1'b0; lock_req = 1'b0;
    supply_mv = 12'd2699; step(); step();
    check("R7 same-cycle code 5 kept, stays on", 1'b1, 1'b0);
    supply_mv = 12'd2799; step();
    check("R8 lock holds code 5 band", 1'b1, 1'b0);
    supply_mv = 12'd2800; step();
    check("R8 code 5 upper trip", 1'b0, 1'b0);
    supply_mv = 12'd2650; step();
    check("R8 code 5 lower trip still active", 1'b1, 1'b0);
    do_reset();
    check("R10 reset clears lock", 1'b0, 1'b0);
    det_en = 1'b1; thr_sel = 3'd0; supply_mv = 12'd2250; step(); step();
    check("R8 writes accepted after reset", 1'b0, 1'b0);
    supply_mv = 12'd2199; step();
    check("R8 code 0 after reset", 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_levels();
    t_irq();
    t_init();
    t_disable();
    t_lock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule